// File: doc/BRIEF.md
# Clock Startup Status Controller

This block is the control and status side of a clock generator built around a crystal oscillator and a frequency-multiplying PLL. Software programs a single mode word through a simple write port. The word turns the oscillator on or off, selects oscillator bypass, sets an oscillator settle count, sets a multiplier value and sets a PLL settle count. The block drives the oscillator power enable, the bypass select and the PLL enable and ratio. The analog parts are not modelled. The block times their settling with two countdown counters and reports the result as two status flags.

The oscillator counter steps once every eight main-clock cycles, using a free-running prescaler. The PLL counter steps once per slow-clock tick, which arrives as a one-cycle enable pulse in the main clock domain. A second write address holds the interrupt enables. The interrupt line is a level. It stays high while any enabled status flag is set.

Top module: `clkstart_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no write yet, osc_pwr, clk_bypass, pll_en, osc_ready, pll_lock and irq are 0 and pll_ratio is 0.
- R2: A write with wr_addr=0 loads the mode word. Its fields are: bit 0 oscillator enable, bit 1 bypass, bits 9:2 oscillator settle count, bits 15:10 multiplier, bits 21:16 PLL settle count. When bit 0 is 1, the write loads the oscillator counter and clears osc_ready in the next cycle.
- R3: After an oscillator load with count N, osc_ready first reads 1 between 8N+1 and 8N+8 cycles after the write edge, on a step of the prescaler. It then stays 1 until the next mode write.
- R4: A mode write with bit 0 equal to 0 makes osc_pwr and osc_ready 0 in the next cycle.
- R5: A mode write whose nonzero multiplier differs from the current one clears pll_lock and loads the PLL counter with count M. pll_lock becomes 1 at the edge of the (M+1)-th slow tick after the write. A write that repeats the current multiplier leaves pll_lock unchanged.
- R6: pll_lock only rises at an edge where slow_tick is 1. Cycles without slow_tick never change it.
- R7: A multiplier of 0 makes pll_en 0, pll_lock 0 and pll_ratio 0. A nonzero multiplier m gives pll_en=1 and pll_ratio=m+1, so the largest ratio is 64.
- R8: clk_bypass equals the stored bypass bit. osc_pwr is 1 only when the oscillator is enabled and bypass is 0.
- R9: A write with wr_addr=1 stores the interrupt enables: bit 0 for osc_ready, bit 1 for pll_lock. irq is 1 exactly while some status flag and its enable are both 1.
- R10: A mode write with bit 0 equal to 1 during an oscillator countdown restarts the countdown from the newly written count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle slow-clock enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the mode word, 1 selects the interrupt enables |
| wr_data | input | 22 | Write data |
| osc_pwr | output | 1 | Oscillator power enable |
| clk_bypass | output | 1 | Use the input clock directly |
| pll_en | output | 1 | PLL enable |
| pll_ratio | output | 7 | Multiplication ratio, 0 when the PLL is off |
| osc_ready | output | 1 | Oscillator settled status |
| pll_lock | output | 1 | PLL settled status |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that slow_tick is already synchronous to clk. They also assume that wr_data and wr_addr matter only in cycles where wr_en is high, and that reset is held for at least one edge before checking starts. The stimulus respects this. It changes every input on the falling edge, drives slow_tick only as isolated one-cycle pulses, and holds reset for several cycles at the start. The oscillator latency is checked as a window, because the prescaler phase at the time of a write is not fixed. The PLL latency is checked exactly, tick by tick.

// File: rtl/clkstart_pkg.sv
// Package: shared codes for the clock startup status controller.
// Assumes a one-bit register address and two interrupt sources.
package clkstart_pkg;
    localparam logic ADDR_MODE  = 1'b0;
    localparam logic ADDR_IRQEN = 1'b1;
    localparam int   NUM_IRQ    = 2;
    localparam int   IRQ_OSC    = 0;
    localparam int   IRQ_PLL    = 1;
    localparam int   POS_OSC_EN = 0;
    localparam int   POS_BYPASS = 1;
    localparam int   POS_OSC_CNT = 2;
endpackage

// File: rtl/clkstart_presc.sv
// Module: free-running prescaler producing one tick every 2**PRESC_W cycles.
// Assumes: the tick phase is set only by reset, never by register writes.
module clkstart_presc #(
    parameter int PRESC_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [PRESC_W-1:0] cnt_q;

    // Advance the prescaler every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Tick on the all-ones state.
    assign tick = &cnt_q;
endmodule

// File: rtl/clkstart_settle.sv
// Module: settle countdown. A load starts it, ticks decrement it, and it
// flags done on the tick seen at zero. Assumes: stop takes priority over load.
module clkstart_settle #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             stop,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             done,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q;

    // Countdown and status state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else if (stop) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (tick && busy) begin
            if (cnt_q == '0) begin
                done <= 1'b1;
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkstart_irq.sv
// Module: interrupt enable register and level interrupt combine.
// Assumes: status inputs are registered flags from the settle counters.
module clkstart_irq #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_wr,
    input  logic [NUM_SRC-1:0] en_data,
    input  logic [NUM_SRC-1:0] status,
    output logic               irq
);
    logic [NUM_SRC-1:0] ie_q;
    logic [NUM_SRC-1:0] hit;

    // Hold the interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= '0;
        else if (en_wr) ie_q <= en_data;
    end

    // Mask each source with its enable.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
        assign hit[i] = status[i] & ie_q[i];
    end

    // Combine the sources into one level.
    assign irq = |hit;
endmodule

// File: rtl/clkstart_ctrl.sv
// Module: top of the clock startup status controller. It holds the mode word,
// drives the oscillator and PLL enables, and times their settling.
// Assumes: slow_tick is a one-cycle pulse synchronous to clk.
module clkstart_ctrl
    import clkstart_pkg::*;
#(
    parameter int OSC_CNT_W = 8,
    parameter int MUL_W     = 6,
    parameter int PLL_CNT_W = 6,
    parameter int PRESC_W   = 3,
    localparam int WORD_W   = 2 + OSC_CNT_W + MUL_W + PLL_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              osc_pwr,
    output logic              clk_bypass,
    output logic              pll_en,
    output logic [MUL_W:0]    pll_ratio,
    output logic              osc_ready,
    output logic              pll_lock,
    output logic              irq
);
    localparam int MUL_LSB = POS_OSC_CNT + OSC_CNT_W;
    localparam int PLL_LSB = MUL_LSB + MUL_W;

    logic                 mode_wr, ie_wr;
    logic                 wr_osc_en, wr_bypass;
    logic [OSC_CNT_W-1:0] wr_osc_cnt;
    logic [MUL_W-1:0]     wr_mul;
    logic [PLL_CNT_W-1:0] wr_pll_cnt;
    logic                 osc_en_q, bypass_q;
    logic [MUL_W-1:0]     mul_q;
    logic                 osc_tick, osc_load, osc_stop, osc_busy;
    logic                 pll_load, pll_stop, pll_busy;
    logic [NUM_IRQ-1:0]   status;

    // Decode the write strobe and split the mode word into fields.
    assign mode_wr    = wr_en && (wr_addr == ADDR_MODE);
    assign ie_wr      = wr_en && (wr_addr == ADDR_IRQEN);
    assign wr_osc_en  = wr_data[POS_OSC_EN];
    assign wr_bypass  = wr_data[POS_BYPASS];
    assign wr_osc_cnt = wr_data[POS_OSC_CNT +: OSC_CNT_W];
    assign wr_mul     = wr_data[MUL_LSB +: MUL_W];
    assign wr_pll_cnt = wr_data[PLL_LSB +: PLL_CNT_W];

    // Store the mode fields that drive the analog enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_en_q <= 1'b0;
            bypass_q <= 1'b0;
            mul_q    <= '0;
        end else if (mode_wr) begin
            osc_en_q <= wr_osc_en;
            bypass_q <= wr_bypass;
            mul_q    <= wr_mul;
        end
    end

    // Turn mode writes into counter loads and stops.
    assign osc_load = mode_wr && wr_osc_en;
    assign osc_stop = mode_wr && !wr_osc_en;
    assign pll_stop = mode_wr && (wr_mul == '0);
    assign pll_load = mode_wr && (wr_mul != '0) && (wr_mul != mul_q);

    // Drive the analog-side outputs from the stored mode.
    assign osc_pwr    = osc_en_q && !bypass_q;
    assign clk_bypass = bypass_q;
    assign pll_en     = (mul_q != '0);
    assign pll_ratio  = pll_en ? ({1'b0, mul_q} + 1'b1) : '0;

    clkstart_presc #(.PRESC_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (osc_tick)
    );

    clkstart_settle #(.CNT_W(OSC_CNT_W)) u_osc_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (osc_load),
        .stop     (osc_stop),
        .load_val (wr_osc_cnt),
        .tick     (osc_tick),
        .done     (osc_ready),
        .busy     (osc_busy)
    );

    clkstart_settle #(.CNT_W(PLL_CNT_W)) u_pll_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pll_load),
        .stop     (pll_stop),
        .load_val (wr_pll_cnt),
        .tick     (slow_tick),
        .done     (pll_lock),
        .busy     (pll_busy)
    );

    // Gather the status flags in interrupt-bit order.
    always_comb begin
        status          = '0;
        status[IRQ_OSC] = osc_ready;
        status[IRQ_PLL] = pll_lock;
    end

    clkstart_irq #(.NUM_SRC(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (ie_wr),
        .en_data (wr_data[NUM_IRQ-1:0]),
        .status  (status),
        .irq     (irq)
    );
endmodule

// File: rtl/clkstart_ctrl_chk.sv
// Module: assertion checker bound to clkstart_ctrl.
// Assumes: the bound signals are the top-level nets of the same names.
module clkstart_ctrl_chk #(
    parameter int MUL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slow_tick,
    input logic             osc_tick,
    input logic             mode_wr,
    input logic [MUL_W-1:0] wr_mul,
    input logic [MUL_W-1:0] mul_q,
    input logic             osc_en_q,
    input logic             osc_pwr,
    input logic             clk_bypass,
    input logic             pll_en,
    input logic             osc_ready,
    input logic             pll_lock,
    input logic             irq
);
    // R3: the oscillator flag rises only on a prescaler step
    assert_osc_on_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_ready) |-> $past(osc_tick));

    // R3: once set, the flag holds until a mode write
    assert_osc_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_ready && !mode_wr) |=> osc_ready);

    // R4: a disabled oscillator never reports ready
    assert_osc_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en_q |-> !osc_ready);

    // R5: a changed multiplier drops the lock
    assert_newmul_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && (wr_mul != mul_q)) |=> !pll_lock);

    // R6: the lock rises only with a slow tick
    assert_lock_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_lock) |-> $past(slow_tick));

    // R7: a zero multiplier means PLL off and unlocked
    assert_pll_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_q == '0) |-> (!pll_en && !pll_lock));

    // R8: bypass keeps the oscillator unpowered
    assert_bypass_nopwr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_bypass |-> !osc_pwr);

    // R9: no status flag, no interrupt
    assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(osc_ready || pll_lock) |-> !irq);
endmodule

bind clkstart_ctrl clkstart_ctrl_chk #(.MUL_W(MUL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_tick  (slow_tick),
    .osc_tick   (osc_tick),
    .mode_wr    (mode_wr),
    .wr_mul     (wr_mul),
    .mul_q      (mul_q),
    .osc_en_q   (osc_en_q),
    .osc_pwr    (osc_pwr),
    .clk_bypass (clk_bypass),
    .pll_en     (pll_en),
    .osc_ready  (osc_ready),
    .pll_lock   (pll_lock),
    .irq        (irq)
);

// File: tb/tb_clkstart_ctrl.sv
module tb_clkstart_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [21:0] wr_data = '0;
    logic        osc_pwr, clk_bypass, pll_en, osc_ready, pll_lock, irq;
    logic [6:0]  pll_ratio;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    clkstart_ctrl dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .osc_pwr(osc_pwr),
        .clk_bypass(clk_bypass), .pll_en(pll_en), .pll_ratio(pll_ratio),
        .osc_ready(osc_ready), .pll_lock(pll_lock), .irq(irq)
    );

    // Vector table: {osc count, multiplier, pll count}
    localparam logic [19:0] VEC [4] = '{
        {8'd3,  6'd5,  6'd2},
        {8'd0,  6'd63, 6'd0},
        {8'd10, 6'd1,  6'd4},
        {8'd1,  6'd20, 6'd7}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_mode(input bit en, input bit byp, input logic [7:0] oc,
                           input logic [5:0] mul, input logic [5:0] pc);
        wr_en = 1'b1;
        wr_addr = 1'b0;
        wr_data = {pc, mul, oc, byp, en};
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic wr_ie(input logic [1:0] ie);
        wr_en = 1'b1;
        wr_addr = 1'b1;
        wr_data = {20'd0, ie};
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic tick_pulse();
        slow_tick = 1'b1;
        cyc();
        slow_tick = 1'b0;
    endtask

    // Cycles from the write edge until osc_ready reads 1.
    task automatic osc_latency(output int lat);
        lat = 0;
        while (!osc_ready && lat < 4000) begin
            cyc();
            lat++;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

    initial begin
        int lat;
        @(negedge clk);
        // R1: state while reset is held
        repeat (3) cyc();
        chk({osc_pwr, clk_bypass, pll_en, osc_ready, pll_lock, irq} == 6'b0 && pll_ratio == 0,
            "R1 during reset", {osc_pwr, pll_en, osc_ready, pll_lock, irq}, 0);
        rst_n = 1'b1;
        repeat (4) cyc();
        chk({osc_pwr, clk_bypass, pll_en, osc_ready, pll_lock, irq} == 6'b0 && pll_ratio == 0,
            "R1 after reset", pll_ratio, 0);

        // Table walk: R2, R3, R5, R6, R7
        for (int i = 0; i < 4; i++) begin
            int oc, mul, pc;
            oc  = int'(VEC[i][19:12]);
            mul = int'(VEC[i][11:6]);
            pc  = int'(VEC[i][5:0]);
            wr_mode(1'b1, 1'b0, oc[7:0], mul[5:0], pc[5:0]);
            chk(pll_lock == 1'b0, "R5 lock cleared on new multiplier", pll_lock, 0);
            chk(osc_pwr == 1'b1, "R8 osc powered", osc_pwr, 1);
            chk(pll_en && pll_ratio == 7'(mul + 1), "R7 ratio", pll_ratio, mul + 1);
            lat = 0;
            if (!osc_ready) osc_latency(lat);
            else lat = -1;
            chk(lat >= 8 * oc + 1 && lat <= 8 * oc + 8, "R3 oscillator latency", lat, 8 * oc + 1);
            chk(pll_lock == 1'b0, "R6 no lock without slow ticks", pll_lock, 0);
            for (int t = 1; t <= pc + 1; t++) begin
                tick_pulse();
                chk(pll_lock == (t == pc + 1), "R5 lock after M+1 ticks", pll_lock, int'(t == pc + 1));
                cyc();
                cyc();
                chk(pll_lock == (t == pc + 1), "R6 lock steady between ticks", pll_lock, int'(t == pc + 1));
            end
            chk(osc_ready == 1'b1, "R3 ready held", osc_ready, 1);
        end

        // R5: repeating the same multiplier keeps the lock (current mult 20)
        wr_mode(1'b1, 1'b0, 8'd2, 6'd20, 6'd3);
        chk(pll_lock == 1'b1, "R5 same multiplier keeps lock", pll_lock, 1);
        // R2: oscillator enable write clears ready
        chk(osc_ready == 1'b0, "R2 ready cleared by reload", osc_ready, 0);

        // R9: interrupt level
        osc_latency(lat);
        chk(irq == 1'b0, "R9 irq masked", irq, 0);
        wr_ie(2'b01);
        chk(irq == 1'b1, "R9 irq from osc_ready", irq, 1);
        wr_ie(2'b10);
        chk(irq == 1'b1, "R9 irq from pll_lock", irq, 1);
        repeat (5) cyc();
        chk(irq == 1'b1, "R9 irq level held", irq, 1);
        wr_ie(2'b00);
        chk(irq == 1'b0, "R9 irq cleared by enable", irq, 0);
        wr_ie(2'b10);

        // R7: multiplier 0 disables the PLL
        wr_mode(1'b1, 1'b0, 8'd2, 6'd0, 6'd3);
        chk(!pll_en && !pll_lock && pll_ratio == 0, "R7 PLL off", {pll_en, pll_lock}, 0);
        chk(irq == 1'b0, "R9 irq drops with status", irq, 0);
        tick_pulse();
        tick_pulse();
        chk(pll_lock == 1'b0, "R7 ticks ignored when off", pll_lock, 0);

        // R4: disabling the oscillator
        osc_latency(lat);
        chk(osc_ready == 1'b1, "R4 precondition ready", osc_ready, 1);
        wr_mode(1'b0, 1'b0, 8'd2, 6'd0, 6'd0);
        chk(!osc_ready && !osc_pwr, "R4 osc off clears ready", {osc_ready, osc_pwr}, 0);
        repeat (40) cyc();
        chk(osc_ready == 1'b0, "R4 stays not ready", osc_ready, 0);

        // R10: restart during countdown
        wr_mode(1'b1, 1'b0, 8'd6, 6'd0, 6'd0);
        repeat (30) cyc();
        chk(osc_ready == 1'b0, "R10 counting", osc_ready, 0);
        wr_mode(1'b1, 1'b0, 8'd6, 6'd0, 6'd0);
        osc_latency(lat);
        chk(lat >= 49 && lat <= 56, "R10 restart latency", lat, 49);

        // R8: bypass
        wr_mode(1'b1, 1'b1, 8'd0, 6'd0, 6'd0);
        chk(clk_bypass && !osc_pwr, "R8 bypass unpowers oscillator", {clk_bypass, osc_pwr}, 2);
        wr_mode(1'b1, 1'b0, 8'd0, 6'd0, 6'd0);
        chk(!clk_bypass && osc_pwr, "R8 bypass off", {clk_bypass, osc_pwr}, 1);

        // R1: reset in mid-operation
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        cyc();
        chk({osc_pwr, clk_bypass, pll_en, osc_ready, pll_lock, irq} == 6'b0,
            "R1 re-reset", osc_pwr, 0);

        finished = 1'b1;
        summary();
    end
endmodule